// File: doc/BRIEF.md
# Segmented SAR Controller with Capacitor Mismatch Calibration

This block is the digital sequencer of a 12-bit charge-redistribution successive-approximation converter. Its array has two parts. The upper segment holds six binary-weighted capacitors plus one extra capacitor whose weight equals the whole lower segment. The lower segment holds six binary-weighted capacitors. The controller drives every capacitor's bottom plate with a 2-bit code that selects common-mode, the positive reference or the negative reference. It strobes the comparator once per decision and powers the comparator's preamplifier down between sample periods.

A normal conversion takes one sampling cycle, then thirteen decision cycles ordered from the heaviest capacitor down. Each decision drives its capacitor to plus or minus. The decision bits are then combined into a weighted sum. Because of the extra capacitor, this sum is re-centred and clipped to a 12-bit code.

In calibration mode the six real upper capacitors are measured in turn, largest first. Each capacitor is measured in three steps:
- The array samples a test pattern.
- The array is driven to the complementary pattern.
- The leftover charge is digitized by a search that uses only the lower segment.

Each result is kept in a 6-bit signed register for the correction logic downstream to use.

Top module: `sar_cal_ctrl`

## Requirements
- R1: While and after rst_n is low (before any request), busy=0, stop=1, lat=0, sample=0, every switch field is 00, dout=0, dout_valid=0, done=0 and every error register is 0.
- R2: Each capacitor has a 2-bit code: 00 common-mode, 01 positive reference, 10 negative reference, and 11 never appears. Field p of msb_sw (bits 2p+1:2p) drives upper position p: position 0 weighs 2048, the weight halves down to position 5 at 64, and position 6 is the extra capacitor of weight 64. Field j of lsb_sw drives weight 2^(5-j). A start seen while idle gives exactly one cycle with sample=1 and every field 00.
- R3: After the sampling cycle come 13 decision cycles for positions 0..12, in that order. Positions 0..6 are the upper fields and position 7+j is lower field j. lat=1 in each decision cycle and cmp_in is taken at the end of that cycle. From the next cycle on, that position holds 01 if cmp_in was 1 and 10 if it was 0. Undecided positions stay 00.
- R4: dout_valid is high for exactly one cycle, the cycle after the last decision. In that cycle dout = S-32, clipped to the range 0..4095. S is the sum of the weights (2048,1024,512,256,128,64,64,32,16,8,4,2,1 for positions 0..12) of all positions whose decision was 1. dout does not change at any other time.
- R5: stop is 1 whenever the controller is idle and 0 from the sampling cycle through the last decision cycle.
- R6: cal_start seen while idle runs capacitors k=0..5 in order. Each starts with one cycle where sample=1. In that cycle upper position k is 01, positions k+1..5 are 10, position 6 is 01, positions below k are 00, and all lower fields are 00.
- R7: The cycle after each calibration sample is a force cycle with sample=0 and lat=0. In it, upper position k is 10, positions k+1..6 are 01 and positions below k are 00.
- R8: Six decision cycles with lat=1 follow each force cycle. They decide lower positions 7..12 by the R3 rule while the upper fields keep the force pattern.
- R9: After capacitor k's sixth decision, cal_err bits 6k+5:6k hold B-32 as 6-bit two's complement. B is the 6-bit value of that capacitor's six decisions, first decision as its MSB.
- R10: cal_start seen during a conversion is held until the conversion ends. The conversion finishes with its normal result, and the first calibration sample cycle comes right after the dout_valid cycle.
- R11: start during calibration is ignored. No dout_valid occurs, dout keeps its value and the calibration sequence keeps its timing.
- R12: busy is 1 from the sampling cycle through the last decision. done is 1 for exactly one cycle, the first idle cycle after a conversion or after a full calibration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a conversion (taken when idle) |
| cal_start | input | 1 | Request a calibration run |
| cmp_in | input | 1 | Comparator decision, 1 = keep positive |
| sample | output | 1 | Bottom-plate sampling switch enable |
| lat | output | 1 | Comparator latch strobe |
| stop | output | 1 | Comparator preamp power-down |
| msb_sw | output | 14 | Upper segment switch codes, 2 bits per position |
| lsb_sw | output | 12 | Lower segment switch codes, 2 bits per position |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| dout | output | 12 | Conversion result |
| dout_valid | output | 1 | One-cycle result strobe |
| cal_err | output | 36 | Six 6-bit signed mismatch codes |

## Verification
Conversions are driven with decision patterns that separate three kinds of fault. All-ones and all-zeros patterns hit both clipping limits. A lone heaviest bit and a lone extra-capacitor bit would expose a wrong weight or a wrong offset. Alternating and mixed patterns would expose bit-order or position swaps. Calibration runs use residual codes at both signed extremes, at zero, at minus one and in two alternating forms, so that a sign-bit or bit-order slip in the error registers shows up. The switch patterns are also compared in every sample and force cycle for every capacitor. A calibration request made in the middle of a conversion and a start made in the middle of a calibration test the hand-off between modes.

// File: rtl/sar_cal_pkg.sv
// Shared types for the SAR controller: switch codes and sequencer states.
package sar_cal_pkg;

    typedef enum logic [1:0] {
        SW_CM  = 2'b00,
        SW_POS = 2'b01,
        SW_NEG = 2'b10
    } sw_code_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SAMP,
        ST_CONV,
        ST_CSAMP,
        ST_CFORCE,
        ST_CBITS
    } sar_st_t;

    // Map one comparator decision to a bottom-plate drive code.
    function automatic sw_code_t dec_to_code(input logic b);
        return b ? SW_POS : SW_NEG;
    endfunction

endpackage

// File: rtl/sar_seq.sv
// Sequencer FSM: walks sample and decision cycles for conversion and the
// sample/force/search steps of calibration. Assumes cmp_in is valid during
// each lat cycle and is captured at that cycle's closing edge.
module sar_seq
    import sar_cal_pkg::*;
#(
    parameter int MSB_N = 7,
    parameter int LSB_N = 6,
    parameter int NPOS  = MSB_N + LSB_N,
    parameter int NCAL  = MSB_N - 1,
    parameter int IDX_W = $clog2(NPOS),
    parameter int K_W   = (NCAL > 1) ? $clog2(NCAL) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cal_start,
    input  logic             cmp_in,
    output sar_st_t          state,
    output logic [IDX_W-1:0] idx,
    output logic [K_W-1:0]   cal_k,
    output logic [NPOS-1:0]  dec,
    output logic [NPOS-1:0]  dec_next,
    output logic             conv_fin,
    output logic             cal_wr,
    output logic             done
);

    logic cal_pend;

    // Decision vector including the bit being decided this cycle.
    always_comb begin
        dec_next = dec;
        if (state == ST_CONV || state == ST_CBITS) begin
            dec_next[idx] = cmp_in;
        end
    end

    // Last-position flags for conversion and for one calibration search.
    always_comb begin
        conv_fin = (state == ST_CONV)  && (idx == IDX_W'(NPOS - 1));
        cal_wr   = (state == ST_CBITS) && (idx == IDX_W'(NPOS - 1));
    end

    // State, counters, decision bits and held calibration request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            idx      <= '0;
            cal_k    <= '0;
            dec      <= '0;
            cal_pend <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    dec <= '0;
                    if (cal_start || cal_pend) begin
                        state    <= ST_CSAMP;
                        cal_k    <= '0;
                        cal_pend <= 1'b0;
                    end else if (start) begin
                        state <= ST_SAMP;
                    end
                end
                ST_SAMP: begin
                    state    <= ST_CONV;
                    idx      <= '0;
                    cal_pend <= cal_pend | cal_start;
                end
                ST_CONV: begin
                    dec      <= dec_next;
                    cal_pend <= cal_pend | cal_start;
                    if (conv_fin) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_CSAMP: begin
                    state <= ST_CFORCE;
                end
                ST_CFORCE: begin
                    state <= ST_CBITS;
                    idx   <= IDX_W'(MSB_N);
                end
                ST_CBITS: begin
                    dec <= dec_next;
                    if (cal_wr) begin
                        dec <= '0;
                        if (cal_k == K_W'(NCAL - 1)) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end else begin
                            cal_k <= cal_k + 1'b1;
                            state <= ST_CSAMP;
                        end
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sar_sw_map.sv
// Switch code generator: turns sequencer state, decision bits and the
// capacitor under calibration into one 2-bit code per bottom plate.
// Assumes position MSB_N-1 is the extra capacitor of the upper segment.
module sar_sw_map
    import sar_cal_pkg::*;
#(
    parameter int MSB_N = 7,
    parameter int LSB_N = 6,
    parameter int NPOS  = MSB_N + LSB_N,
    parameter int IDX_W = $clog2(NPOS),
    parameter int K_W   = 3
) (
    input  sar_st_t            state,
    input  logic [IDX_W-1:0]   idx,
    input  logic [K_W-1:0]     cal_k,
    input  logic [NPOS-1:0]    dec,
    output logic [2*MSB_N-1:0] msb_sw,
    output logic [2*LSB_N-1:0] lsb_sw
);

    for (genvar p = 0; p < MSB_N; p++) begin : g_msb
        // Upper-segment code for position p in every state.
        always_comb begin
            sw_code_t c;
            c = SW_CM;
            case (state)
                ST_CONV: begin
                    if (int'(idx) > p) c = dec_to_code(dec[p]);
                end
                ST_CSAMP: begin
                    if (p == MSB_N - 1)       c = SW_POS;
                    else if (int'(cal_k) == p) c = SW_POS;
                    else if (int'(cal_k) < p)  c = SW_NEG;
                end
                ST_CFORCE, ST_CBITS: begin
                    if (int'(cal_k) == p)     c = SW_NEG;
                    else if (int'(cal_k) < p) c = SW_POS;
                end
                default: c = SW_CM;
            endcase
            msb_sw[2*p +: 2] = c;
        end
    end

    for (genvar j = 0; j < LSB_N; j++) begin : g_lsb
        // Lower-segment code: decided positions only, otherwise common-mode.
        always_comb begin
            sw_code_t c;
            c = SW_CM;
            if ((state == ST_CONV || state == ST_CBITS) &&
                (int'(idx) > MSB_N + j)) begin
                c = dec_to_code(dec[MSB_N + j]);
            end
            lsb_sw[2*j +: 2] = c;
        end
    end

endmodule

// File: rtl/sar_result.sv
// Result assembly: weighted sum of all decisions (upper weights, extra
// capacitor, lower weights), re-centred by half the extra weight and
// clipped to the output range. Purely combinational.
module sar_result #(
    parameter int MSB_N = 7,
    parameter int LSB_N = 6,
    parameter int NPOS  = MSB_N + LSB_N,
    parameter int RES   = MSB_N - 1 + LSB_N
) (
    input  logic [NPOS-1:0] dec_bits,
    output logic [RES-1:0]  code
);

    localparam int SUM_W = RES + 1;
    localparam logic [SUM_W-1:0] OFS  = SUM_W'(1) << (LSB_N - 1);
    localparam logic [SUM_W-1:0] CMAX = (SUM_W'(1) << RES) - SUM_W'(1);

    // Weight of a decision position.
    function automatic logic [SUM_W-1:0] pos_weight(input int p);
        if (p < MSB_N - 1)       return SUM_W'(1) << (RES - 1 - p);
        else if (p == MSB_N - 1) return SUM_W'(1) << LSB_N;
        else                     return SUM_W'(1) << (NPOS - 1 - p);
    endfunction

    logic [SUM_W-1:0] total;

    // Sum weights of positions decided as one.
    always_comb begin
        total = '0;
        for (int p = 0; p < NPOS; p++) begin
            if (dec_bits[p]) total = total + pos_weight(p);
        end
    end

    // Re-centre and clip.
    always_comb begin
        if (total < OFS)              code = '0;
        else if (total - OFS > CMAX)  code = CMAX[RES-1:0];
        else                          code = RES'(total - OFS);
    end

endmodule

// File: rtl/sar_err_bank.sv
// Mismatch error registers, one per calibrated capacitor. Stores the
// lower-segment search result minus half scale as signed two's complement.
// Assumes dec_lsb bit 0 is the first (heaviest) lower decision.
module sar_err_bank #(
    parameter int LSB_N = 6,
    parameter int NCAL  = 6,
    parameter int K_W   = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr,
    input  logic [K_W-1:0]        wr_k,
    input  logic [LSB_N-1:0]      dec_lsb,
    output logic [NCAL*LSB_N-1:0] cal_err
);

    logic [LSB_N-1:0] raw;
    logic [LSB_N-1:0] signed_val;

    // Reorder decisions so the first one becomes the MSB, then remove half scale.
    always_comb begin
        for (int j = 0; j < LSB_N; j++) raw[LSB_N-1-j] = dec_lsb[j];
        signed_val = {~raw[LSB_N-1], raw[LSB_N-2:0]};
    end

    for (genvar k = 0; k < NCAL; k++) begin : g_reg
        // Register k captures at the end of its own search.
        always_ff @(posedge clk) begin
            if (!rst_n)                         cal_err[k*LSB_N +: LSB_N] <= '0;
            else if (wr && wr_k == K_W'(k))     cal_err[k*LSB_N +: LSB_N] <= signed_val;
        end
    end

endmodule

// File: rtl/sar_cal_ctrl.sv
// Top of the segmented SAR controller with capacitor calibration.
// Assumes a comparator that settles within one lat cycle and an array with
// MSB_N-1 binary upper capacitors, one extra capacitor equal to the lower
// segment, and LSB_N binary lower capacitors.
module sar_cal_ctrl
    import sar_cal_pkg::*;
#(
    parameter int MSB_N = 7,
    parameter int LSB_N = 6
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start,
    input  logic                              cal_start,
    input  logic                              cmp_in,
    output logic                              sample,
    output logic                              lat,
    output logic                              stop,
    output logic [2*MSB_N-1:0]                msb_sw,
    output logic [2*LSB_N-1:0]                lsb_sw,
    output logic                              busy,
    output logic                              done,
    output logic [MSB_N+LSB_N-2:0]            dout,
    output logic                              dout_valid,
    output logic [(MSB_N-1)*LSB_N-1:0]        cal_err
);

    localparam int NPOS  = MSB_N + LSB_N;
    localparam int RES   = MSB_N - 1 + LSB_N;
    localparam int NCAL  = MSB_N - 1;
    localparam int IDX_W = $clog2(NPOS);
    localparam int K_W   = (NCAL > 1) ? $clog2(NCAL) : 1;

    sar_st_t          state;
    logic [IDX_W-1:0] idx;
    logic [K_W-1:0]   cal_k;
    logic [NPOS-1:0]  dec;
    logic [NPOS-1:0]  dec_next;
    logic             conv_fin;
    logic             cal_wr;
    logic [RES-1:0]   res_code;

    sar_seq #(
        .MSB_N(MSB_N), .LSB_N(LSB_N), .NPOS(NPOS), .NCAL(NCAL),
        .IDX_W(IDX_W), .K_W(K_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .cal_start(cal_start),
        .cmp_in(cmp_in), .state(state), .idx(idx), .cal_k(cal_k),
        .dec(dec), .dec_next(dec_next), .conv_fin(conv_fin),
        .cal_wr(cal_wr), .done(done)
    );

    sar_sw_map #(
        .MSB_N(MSB_N), .LSB_N(LSB_N), .NPOS(NPOS), .IDX_W(IDX_W), .K_W(K_W)
    ) u_map (
        .state(state), .idx(idx), .cal_k(cal_k), .dec(dec),
        .msb_sw(msb_sw), .lsb_sw(lsb_sw)
    );

    sar_result #(
        .MSB_N(MSB_N), .LSB_N(LSB_N), .NPOS(NPOS), .RES(RES)
    ) u_res (
        .dec_bits(dec_next), .code(res_code)
    );

    sar_err_bank #(
        .LSB_N(LSB_N), .NCAL(NCAL), .K_W(K_W)
    ) u_err (
        .clk(clk), .rst_n(rst_n), .wr(cal_wr), .wr_k(cal_k),
        .dec_lsb(dec_next[MSB_N +: LSB_N]), .cal_err(cal_err)
    );

    // Comparator and sampling controls decoded from the state.
    always_comb begin
        busy   = (state != ST_IDLE);
        stop   = (state == ST_IDLE);
        lat    = (state == ST_CONV) || (state == ST_CBITS);
        sample = (state == ST_SAMP) || (state == ST_CSAMP);
    end

    // Output register: result captured on the last conversion decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout       <= '0;
            dout_valid <= 1'b0;
        end else begin
            dout_valid <= conv_fin;
            if (conv_fin) dout <= res_code;
        end
    end

endmodule

// File: rtl/sar_cal_ctrl_chk.sv
// Property checker for sar_cal_ctrl, attached by bind below.
module sar_cal_ctrl_chk #(
    parameter int MSB_N = 7,
    parameter int LSB_N = 6
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     sample,
    input logic                     lat,
    input logic                     stop,
    input logic                     busy,
    input logic                     done,
    input logic [2*MSB_N-1:0]       msb_sw,
    input logic [2*LSB_N-1:0]       lsb_sw,
    input logic [MSB_N+LSB_N-2:0]   dout,
    input logic                     dout_valid
);

    p_lsb_cm_sample_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sample |-> (lsb_sw == '0));

    p_sample_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sample |=> !sample);

    for (genvar p = 0; p < MSB_N; p++) begin : g_mc
        p_legal_msb_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
            msb_sw[2*p +: 2] != 2'b11);
    end
    for (genvar j = 0; j < LSB_N; j++) begin : g_lc
        p_legal_lsb_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
            lsb_sw[2*j +: 2] != 2'b11);
    end

    p_lat_in_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lat |-> (busy && !sample));

    p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid |=> !dout_valid);

    p_dout_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_valid |-> $stable(dout));

    p_stop_at_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid |-> (stop && !busy));

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_busy_begins_sampling_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> sample);

endmodule

bind sar_cal_ctrl sar_cal_ctrl_chk #(.MSB_N(MSB_N), .LSB_N(LSB_N)) u_chk (
    .clk(clk), .rst_n(rst_n), .sample(sample), .lat(lat), .stop(stop),
    .busy(busy), .done(done), .msb_sw(msb_sw), .lsb_sw(lsb_sw),
    .dout(dout), .dout_valid(dout_valid)
);

// File: tb/sar_cal_ctrl_tb.sv
// Self-checking bench for sar_cal_ctrl: vector table of conversions, then
// directed calibration and mode-interaction tests.
module sar_cal_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        cal_start = 1'b0;
    logic        cmp_in = 1'b0;
    logic        sample, lat, stop, busy, done, dout_valid;
    logic [13:0] msb_sw;
    logic [11:0] lsb_sw;
    logic [11:0] dout;
    logic [35:0] cal_err;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    localparam logic [12:0] VEC [0:7] = '{
        13'h1FFF, 13'h0000, 13'h1000, 13'h0040,
        13'h1555, 13'h0AAA, 13'h0FFF, 13'h1F80
    };
    localparam logic [35:0] CAL_A = {6'h2A, 6'h15, 6'h1F, 6'h20, 6'h3F, 6'h00};
    localparam logic [35:0] CAL_B = {6'h01, 6'h3E, 6'h33, 6'h0C, 6'h21, 6'h1E};

    always #10 clk = ~clk;

    sar_cal_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cal_start(cal_start),
        .cmp_in(cmp_in), .sample(sample), .lat(lat), .stop(stop),
        .msb_sw(msb_sw), .lsb_sw(lsb_sw), .busy(busy), .done(done),
        .dout(dout), .dout_valid(dout_valid), .cal_err(cal_err)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] code_at(input int p);
        if (p < 7) return msb_sw[2*p +: 2];
        return lsb_sw[2*(p-7) +: 2];
    endfunction

    // Expected result from decision bits, decision i at bit 12-i.
    function automatic int exp_code(input logic [12:0] v);
        int w [0:12] = '{2048, 1024, 512, 256, 128, 64, 64, 32, 16, 8, 4, 2, 1};
        int s = 0;
        for (int i = 0; i < 13; i++) if (v[12-i]) s += w[i];
        if (s < 32) return 0;
        if (s - 32 > 4095) return 4095;
        return s - 32;
    endfunction

    // Expected upper pattern: kind 0 = calibration sample, 1 = force.
    function automatic logic [13:0] exp_msb(input int kind, input int k);
        logic [13:0] r = '0;
        for (int p = 0; p < 7; p++) begin
            logic [1:0] c = 2'b00;
            if (kind == 0) begin
                if (p == 6 || p == k) c = 2'b01;
                else if (p > k)       c = 2'b10;
            end else begin
                if (p == k)      c = 2'b10;
                else if (p > k)  c = 2'b01;
            end
            r[2*p +: 2] = c;
        end
        return r;
    endfunction

    task automatic run_conv(input logic [12:0] v, input bit inject_cal);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 sample high", sample, 1);
        chk("R2 upper all common in sample", msb_sw, 0);
        chk("R2 lower all common in sample", lsb_sw, 0);
        chk("R5 stop low in sample", stop, 0);
        chk("R12 busy in sample", busy, 1);
        @(negedge clk);
        for (int i = 0; i < 13; i++) begin
            cmp_in = v[12-i];
            cal_start = (inject_cal && i == 3);
            chk("R3 lat in decision", lat, 1);
            chk("R5 stop low in decision", stop, 0);
            if (i > 0) chk("R3 decided code", code_at(i-1), v[13-i] ? 2'b01 : 2'b10);
            if (i < 12) chk("R3 undecided common", code_at(i+1), 2'b00);
            @(negedge clk);
        end
        cal_start = 1'b0;
        chk("R4 valid pulse", dout_valid, 1);
        chk("R4 result", dout, exp_code(v));
        chk("R12 done after conversion", done, 1);
        chk("R12 busy cleared", busy, 0);
        chk("R5 stop when idle", stop, 1);
    endtask

    // Starts at the negedge inside the first calibration sample cycle.
    task automatic cal_body(input logic [35:0] bits, input bit inj_start);
        logic [11:0] held = dout;
        for (int k = 0; k < 6; k++) begin
            chk("R6 sample in cal", sample, 1);
            chk("R6 sample pattern", msb_sw, exp_msb(0, k));
            chk("R6 lower common", lsb_sw, 0);
            @(negedge clk);
            chk("R7 force no sample", sample, 0);
            chk("R7 force no lat", lat, 0);
            chk("R7 force pattern", msb_sw, exp_msb(1, k));
            @(negedge clk);
            for (int j = 0; j < 6; j++) begin
                cmp_in = bits[6*k + 5 - j];
                start = (inj_start && k == 2 && j == 1);
                chk("R8 lat in search", lat, 1);
                chk("R8 upper held", msb_sw, exp_msb(1, k));
                chk("R11 no valid in cal", dout_valid, 0);
                if (j > 0) chk("R8 lower decided", code_at(6 + j),
                               bits[6*k + 6 - j] ? 2'b01 : 2'b10);
                @(negedge clk);
            end
            start = 1'b0;
        end
        chk("R12 done after cal", done, 1);
        chk("R12 idle after cal", busy, 0);
        chk("R11 dout unchanged", dout, held);
        for (int k = 0; k < 6; k++) begin
            logic [5:0] e = 6'(int'(bits[6*k +: 6]) - 32);
            chk("R9 error register", cal_err[6*k +: 6], e);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 busy", busy, 0);
        chk("R1 stop", stop, 1);
        chk("R1 lat", lat, 0);
        chk("R1 sample", sample, 0);
        chk("R1 switches", {msb_sw, lsb_sw}, 0);
        chk("R1 dout", dout, 0);
        chk("R1 valid", dout_valid, 0);
        chk("R1 done", done, 0);
        chk("R1 errors", cal_err, 0);
        rst_n = 1'b1;
        @(negedge clk);
        foreach (VEC[v]) begin
            run_conv(VEC[v], 1'b0);
            @(negedge clk);
            chk("R4 valid one cycle", dout_valid, 0);
        end
        cal_start = 1'b1;
        @(negedge clk);
        cal_start = 1'b0;
        cal_body(CAL_A, 1'b1);
        @(negedge clk);
        run_conv(13'h0D0B, 1'b1);
        @(negedge clk);
        chk("R10 held request starts", sample, 1);
        chk("R10 busy after hand-off", busy, 1);
        cal_body(CAL_B, 1'b0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!finished) begin
            n_fail++;
            $display("FAIL R12 watchdog: actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule